// File: doc/BRIEF.md
# Instruction Fetch-Decode Control Sequencer

This block is the control state machine of a small accumulator processor. It steps through instruction fetch, decode, optional operand fetch and execute, and in each step it raises a single-cycle register-transfer control point: program counter to memory address register, memory access (read or write), memory buffer to instruction register, instruction register to memory address register, and program counter increment. In the execute step it raises one strobe per instruction. The datapath around it acts on these strobes; the sequencer only watches the instruction register.

Every state is held for `SETTLE_CYC` clocks, so memory, decoders and registers have time to settle. Control points fire only in the first clock of a state. The opcode is the upper 8 bits of the instruction word. An internal decoder compares all 8 bits against the instruction set and yields a one-hot vector. Each instruction belongs to one of three operand classes, and the class picks the path taken after decode.

States: `ST_FETCH_ADDR`, `ST_FETCH_READ`, `ST_LOAD_IR`, `ST_DECODE`, `ST_OPND_ADDR`, `ST_OPND_READ`, `ST_EXECUTE`. Transitions: FETCH_ADDR→FETCH_READ→LOAD_IR→DECODE (unconditional); DECODE→OPND_ADDR (operand instruction), DECODE→EXECUTE (no operand), DECODE→FETCH_ADDR (undefined opcode); OPND_ADDR→OPND_READ (read class), OPND_ADDR→EXECUTE (address-only class); OPND_READ→EXECUTE; EXECUTE→FETCH_ADDR. Each transition is taken on the last clock of the current state.

Top module: `ctl_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the sequencer is in ST_FETCH_ADDR at the first cycle of the state. `pc_to_mar` is 1, and `mem_en`, `mem_we`, `mbr_to_ir`, `ir_to_mar`, `pc_inc` and `exec_stb` are all 0.
- R2: Every instruction begins with a `pc_to_mar` pulse. Exactly SETTLE_CYC cycles later a read pulse follows (`mem_en`=1, `mem_we`=0), and SETTLE_CYC cycles after that a `mbr_to_ir` pulse follows. No condition is sampled along this path.
- R3: Every state lasts exactly SETTLE_CYC cycles, and control points pulse only in its first cycle. An instruction therefore takes (states visited)×SETTLE_CYC cycles. Its execute strobe falls at cycle (states−1)×SETTLE_CYC, counted from the `pc_to_mar` cycle.
- R4: The opcode is `ir[IR_W-1 -: 8]`, and all 8 bits are compared. The lower IR bits have no effect. The codes are LOAD=0x10 (bit 0), ADD=0x11 (bit 1), SUB=0x12 (bit 2), STORE=0x20 (bit 3), JUMP=0x21 (bit 4), CLEAR=0x30 (bit 5), NEGATE=0x31 (bit 6), NOP=0x3F (bit 7). The bit given is the instruction's position in `exec_stb`.
- R5: LOAD, ADD and SUB visit 7 states. They raise `ir_to_mar` once and an operand read pulse once, so each instruction makes 2 reads in total.
- R6: STORE and JUMP visit 6 states. They raise `ir_to_mar` once and make no operand read.
- R7: CLEAR, NEGATE and NOP visit 5 states. They go from decode straight to execute and raise no `ir_to_mar`.
- R8: Each defined instruction raises `exec_stb` exactly once: one clock with only its own bit set, in the first cycle of ST_EXECUTE.
- R9: An undefined opcode visits 4 states and then returns to ST_FETCH_ADDR. It raises no `exec_stb` and no `ir_to_mar`.
- R10: `pc_inc` pulses exactly once per instruction, in the same cycle as `mbr_to_ir`.
- R11: The clock after the execute state's last cycle carries the next `pc_to_mar` pulse.
- R12: `mem_we` is 1 only together with `mem_en`, and only in the execute strobe of STORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir | input | IR_W | Current instruction register contents |
| pc_to_mar | output | 1 | Copy program counter into memory address register |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable (valid with mem_en) |
| mbr_to_ir | output | 1 | Copy memory buffer register into instruction register |
| ir_to_mar | output | 1 | Copy IR address field into memory address register |
| pc_inc | output | 1 | Increment program counter |
| exec_stb | output | 8 | One-hot execute strobe per instruction |

## Verification
Some properties are checked on every cycle: exec_stb never has more than one bit set; the fetch-side control points never coincide; writes are never raised without memory access; pc_inc and mbr_to_ir always pair; and the fixed spacing from pc_to_mar to the read, from the read to the IR load, and from execute back to pc_to_mar holds. Other behaviours show only in the bench's instruction scenarios: which path each operand class takes, the total length of each instruction, that the low IR bits and near-miss opcodes do not select an instruction, and that a reset in mid-instruction restarts the fetch cleanly.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    localparam int OPC_W     = 8;
    localparam int NUM_INSTR = 8;
    localparam int IX_STORE  = 3;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_FETCH_READ = 3'd1,
        ST_LOAD_IR    = 3'd2,
        ST_DECODE     = 3'd3,
        ST_OPND_ADDR  = 3'd4,
        ST_OPND_READ  = 3'd5,
        ST_EXECUTE    = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_READ = 2'd1,
        CLS_ADDR = 2'd2
    } opnd_cls_e;

    // opcode assigned to each one-hot position
    function automatic logic [OPC_W-1:0] opc_of(input int idx);
        case (idx)
            0:       return 8'h10; // LOAD
            1:       return 8'h11; // ADD
            2:       return 8'h12; // SUB
            3:       return 8'h20; // STORE
            4:       return 8'h21; // JUMP
            5:       return 8'h30; // CLEAR
            6:       return 8'h31; // NEGATE
            default: return 8'h3F; // NOP
        endcase
    endfunction

    function automatic opnd_cls_e cls_of(input int idx);
        if (idx <= 2)      return CLS_READ;
        else if (idx <= 4) return CLS_ADDR;
        else               return CLS_NONE;
    endfunction

endpackage

// File: rtl/ctl_opcode_decoder.sv
module ctl_opcode_decoder
    import ctl_seq_pkg::*;
(
    input  logic [OPC_W-1:0]     opc,
    output logic [NUM_INSTR-1:0] hot,
    output logic                 cls_read,
    output logic                 cls_addr,
    output logic                 cls_none
);

    logic [NUM_INSTR-1:0] rd_bits;
    logic [NUM_INSTR-1:0] ad_bits;
    logic [NUM_INSTR-1:0] nn_bits;

    for (genvar i = 0; i < NUM_INSTR; i++) begin : g_line
        localparam logic [OPC_W-1:0] CODE = opc_of(i);
        localparam opnd_cls_e        CLS  = cls_of(i);
        assign hot[i]     = (opc == CODE);
        assign rd_bits[i] = hot[i] && (CLS == CLS_READ);
        assign ad_bits[i] = hot[i] && (CLS == CLS_ADDR);
        assign nn_bits[i] = hot[i] && (CLS == CLS_NONE);
    end

    assign cls_read = |rd_bits;
    assign cls_addr = |ad_bits;
    assign cls_none = |nn_bits;

endmodule

// File: rtl/ctl_settle_timer.sv
module ctl_settle_timer #(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic first,
    output logic last
);

    if (SETTLE_CYC <= 1) begin : g_single
        assign first = 1'b1;
        assign last  = 1'b1;
    end else begin : g_count
        localparam int CW = $clog2(SETTLE_CYC);
        localparam logic [CW-1:0] LAST_V = CW'(SETTLE_CYC - 1);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (last) cnt <= '0;
            else           cnt <= cnt + 1'b1;
        end

        assign first = (cnt == '0);
        assign last  = (cnt == LAST_V);
    end

endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
    import ctl_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 first,
    input  logic                 last,
    input  logic [NUM_INSTR-1:0] hot,
    input  logic                 cls_read,
    input  logic                 cls_addr,
    input  logic                 cls_none,
    output logic                 pc_to_mar,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic                 mbr_to_ir,
    output logic                 ir_to_mar,
    output logic                 pc_inc,
    output logic [NUM_INSTR-1:0] exec_stb
);

    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (last) begin
            unique case (state)
                ST_FETCH_ADDR: state_nx = ST_FETCH_READ;
                ST_FETCH_READ: state_nx = ST_LOAD_IR;
                ST_LOAD_IR:    state_nx = ST_DECODE;
                ST_DECODE: begin
                    if (cls_read || cls_addr) state_nx = ST_OPND_ADDR;
                    else if (cls_none)        state_nx = ST_EXECUTE;
                    else                      state_nx = ST_FETCH_ADDR;
                end
                ST_OPND_ADDR:  state_nx = cls_read ? ST_OPND_READ : ST_EXECUTE;
                ST_OPND_READ:  state_nx = ST_EXECUTE;
                ST_EXECUTE:    state_nx = ST_FETCH_ADDR;
                default:       state_nx = ST_FETCH_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH_ADDR;
        else        state <= state_nx;
    end

    always_comb begin
        logic in_exec;
        in_exec   = (state == ST_EXECUTE) && first;
        pc_to_mar = (state == ST_FETCH_ADDR) && first;
        mbr_to_ir = (state == ST_LOAD_IR) && first;
        pc_inc    = (state == ST_LOAD_IR) && first;
        ir_to_mar = (state == ST_OPND_ADDR) && first;
        mem_we    = in_exec && hot[IX_STORE];
        mem_en    = (((state == ST_FETCH_READ) || (state == ST_OPND_READ)) && first)
                    || mem_we;
        exec_stb  = hot & {NUM_INSTR{in_exec}};
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import ctl_seq_pkg::*;
#(
    parameter int IR_W       = 16,
    parameter int SETTLE_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IR_W-1:0]      ir,
    output logic                 pc_to_mar,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic                 mbr_to_ir,
    output logic                 ir_to_mar,
    output logic                 pc_inc,
    output logic [NUM_INSTR-1:0] exec_stb
);

    localparam int LOW_W = IR_W - OPC_W;

    logic [OPC_W-1:0]     opc;
    logic [NUM_INSTR-1:0] hot;
    logic                 cls_read, cls_addr, cls_none;
    logic                 first, last;
    logic                 unused_ir_low;

    assign opc           = ir[IR_W-1 -: OPC_W];
    assign unused_ir_low = ^ir[LOW_W-1:0];

    ctl_opcode_decoder u_dec (
        .opc      (opc),
        .hot      (hot),
        .cls_read (cls_read),
        .cls_addr (cls_addr),
        .cls_none (cls_none)
    );

    ctl_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .first (first),
        .last  (last)
    );

    ctl_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .first     (first),
        .last      (last),
        .hot       (hot),
        .cls_read  (cls_read),
        .cls_addr  (cls_addr),
        .cls_none  (cls_none),
        .pc_to_mar (pc_to_mar),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mbr_to_ir (mbr_to_ir),
        .ir_to_mar (ir_to_mar),
        .pc_inc    (pc_inc),
        .exec_stb  (exec_stb)
    );

endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk
    import ctl_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pc_to_mar,
    input logic                 mem_en,
    input logic                 mem_we,
    input logic                 mbr_to_ir,
    input logic                 ir_to_mar,
    input logic                 pc_inc,
    input logic [NUM_INSTR-1:0] exec_stb
);

    localparam int SMAX = 8 * SETTLE_CYC;
    localparam int SW   = $clog2(SMAX + 1);
    localparam logic [SW-1:0] SMAX_V = SW'(SMAX);
    localparam logic [SW-1:0] ONE_S  = SW'(SETTLE_CYC);
    localparam logic [SW-1:0] TWO_S  = SW'(2 * SETTLE_CYC);

    logic [SW-1:0] since_ptm;
    logic [SW-1:0] since_ex;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_ptm <= '0;
            since_ex  <= '0;
        end else begin
            if (pc_to_mar)                                 since_ptm <= SW'(1);
            else if (since_ptm != '0 && since_ptm != SMAX_V) since_ptm <= since_ptm + 1'b1;
            if (|exec_stb)                                 since_ex <= SW'(1);
            else if (pc_to_mar)                            since_ex <= '0;
            else if (since_ex != '0 && since_ex != SMAX_V)   since_ex <= since_ex + 1'b1;
        end
    end

    // R8
    exec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_stb));

    // R2
    ctl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_to_mar, mbr_to_ir, ir_to_mar, mem_en}));

    // R12
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en && exec_stb[IX_STORE]));

    // R10
    pcinc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc == mbr_to_ir);

    // R2
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ptm == ONE_S) |-> (mem_en && !mem_we));

    // R2
    irload_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ptm == TWO_S) |-> mbr_to_ir);

    // R3
    ptm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_to_mar |=> !pc_to_mar);

    // R11
    exec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ex == ONE_S) |-> pc_to_mar);

endmodule

bind ctl_sequencer ctl_sequencer_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_to_mar (pc_to_mar),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mbr_to_ir (mbr_to_ir),
    .ir_to_mar (ir_to_mar),
    .pc_inc    (pc_inc),
    .exec_stb  (exec_stb)
);

// File: tb/sim_ctl_sequencer.sv
module sim_ctl_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;
    localparam int IR_W       = 16;
    localparam int NI         = 8;
    localparam int NVEC       = 12;

    // {ir[15:0], states[3:0], exec[7:0], ir_to_mar[1:0], reads[1:0], writes[1:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {16'h1000, 4'd7, 8'h01, 2'd1, 2'd2, 2'd0},  // LOAD
        {16'h11A5, 4'd7, 8'h02, 2'd1, 2'd2, 2'd0},  // ADD
        {16'h12FF, 4'd7, 8'h04, 2'd1, 2'd2, 2'd0},  // SUB
        {16'h2040, 4'd6, 8'h08, 2'd1, 2'd1, 2'd1},  // STORE
        {16'h2100, 4'd6, 8'h10, 2'd1, 2'd1, 2'd0},  // JUMP
        {16'h3000, 4'd5, 8'h20, 2'd0, 2'd1, 2'd0},  // CLEAR
        {16'h3111, 4'd5, 8'h40, 2'd0, 2'd1, 2'd0},  // NEGATE
        {16'h3F3F, 4'd5, 8'h80, 2'd0, 2'd1, 2'd0},  // NOP
        {16'h0011, 4'd4, 8'h00, 2'd0, 2'd1, 2'd0},  // undefined, low byte = ADD code
        {16'h9010, 4'd4, 8'h00, 2'd0, 2'd1, 2'd0},  // LOAD with bit 7 set
        {16'hFF10, 4'd4, 8'h00, 2'd0, 2'd1, 2'd0},  // undefined
        {16'h1011, 4'd7, 8'h01, 2'd1, 2'd2, 2'd0}   // LOAD, low byte ignored
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IR_W-1:0] ir_q = '0;
    logic [IR_W-1:0] mbr = '0;
    logic            pc_to_mar, mem_en, mem_we, mbr_to_ir, ir_to_mar, pc_inc;
    logic [NI-1:0]   exec_stb;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // datapath model: instruction register
    always_ff @(posedge clk) if (mbr_to_ir) ir_q <= mbr;

    ctl_sequencer #(.IR_W(IR_W), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .ir(ir_q),
        .pc_to_mar(pc_to_mar), .mem_en(mem_en), .mem_we(mem_we),
        .mbr_to_ir(mbr_to_ir), .ir_to_mar(ir_to_mar), .pc_inc(pc_inc),
        .exec_stb(exec_stb)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic string cls_tag(input int states);
        case (states)
            7:       return "R5";
            6:       return "R6";
            5:       return "R7";
            default: return "R9";
        endcase
    endfunction

    // Call at a negedge where pc_to_mar is high; returns at the next such negedge.
    task automatic run_instr(input logic [IR_W-1:0] word, input int states,
                             input logic [NI-1:0] ex, input int irm, input int rd, input int wr);
        int cyc = 0, ex_cnt = 0, ex_at = -1, rd_cnt = 0, rd_at = -1, wr_cnt = 0;
        int irm_cnt = 0, pci_cnt = 0, mbr_cnt = 0, mbr_at = -1;
        logic [NI-1:0] ex_or = '0;
        string tg = cls_tag(states);
        mbr = word;
        do begin
            if (mem_en && !mem_we) begin rd_cnt++; if (rd_at < 0) rd_at = cyc; end
            if (mem_en && mem_we)  wr_cnt++;
            if (ir_to_mar) irm_cnt++;
            if (pc_inc)    pci_cnt++;
            if (mbr_to_ir) begin mbr_cnt++; if (mbr_at < 0) mbr_at = cyc; end
            if (|exec_stb) begin ex_cnt++; ex_or |= exec_stb; if (ex_at < 0) ex_at = cyc; end
            cyc++;
            @(negedge clk);
        end while (!pc_to_mar && cyc < 200);
        check("R3/R11", "instruction cycles", cyc, states * SETTLE);
        check("R4/R8", "exec vector", int'(ex_or), int'(ex));
        check(states == 4 ? "R9" : "R8", "exec pulses", ex_cnt, (ex != 0) ? 1 : 0);
        if (ex != 0) check("R3", "exec position", ex_at, (states - 1) * SETTLE);
        check(tg, "ir_to_mar pulses", irm_cnt, irm);
        check(tg, "read pulses", rd_cnt, rd);
        check("R12", "write pulses", wr_cnt, wr);
        check("R10", "pc_inc pulses", pci_cnt, 1);
        check("R2", "mbr_to_ir pulses", mbr_cnt, 1);
        check("R2", "first read position", rd_at, SETTLE);
        check("R2", "ir load position", mbr_at, 2 * SETTLE);
    endtask

    task automatic check_reset_outputs();
        check("R1", "pc_to_mar", int'(pc_to_mar), 1);
        check("R1", "mem_en", int'(mem_en), 0);
        check("R1", "mem_we", int'(mem_we), 0);
        check("R1", "mbr_to_ir", int'(mbr_to_ir), 0);
        check("R1", "ir_to_mar", int'(ir_to_mar), 0);
        check("R1", "pc_inc", int'(pc_inc), 0);
        check("R1", "exec_stb", int'(exec_stb), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_outputs();                // R1 while reset is held
        rst_n = 1'b1;
        check_reset_outputs();                // R1 first cycle after release

        for (int v = 0; v < NVEC; v++) begin
            run_instr(VEC[v][33:18], int'(VEC[v][17:14]), VEC[v][13:6],
                      int'(VEC[v][5:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]));
        end

        // mid-instruction reset: LOAD interrupted after its IR load (R1)
        mbr = 16'h1000;
        repeat (2 * SETTLE + 1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_outputs();
        // fresh instruction after restart: STORE then NOP (R6, R7, R12)
        run_instr(16'h2055, 6, 8'h08, 1, 1, 1);
        run_instr(16'h3F00, 5, 8'h80, 0, 1, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule